// File: doc/BRIEF.md
# Framed Serial Command Receiver

This block takes 32-bit write frames from a three-wire serial host: an active-low select line, a serial clock and a data line. It samples all three pins in a faster system clock domain. Each bit is shifted in, most significant bit first, on a falling edge of the serial clock. When the 32nd falling edge arrives the frame is accepted. The block then presents a 4-bit command, a 4-bit address and a 16-bit data field, together with a strobe that lasts one system cycle.

If the host raises select before the 32nd falling edge, the partial frame is discarded and nothing is reported. After an accepted frame, further serial clock edges have no effect until select has gone high and then low again. The block does not interpret the fields it delivers. A downstream decoder acts on them.

Top module: `serial_frame_rx`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `frame_valid` is 0 and `cmd`, `addr` and `data` are all zero.
- R2: Each accepted frame produces exactly one `frame_valid` pulse, and that pulse is one system cycle wide.
- R3: Bits are taken most significant bit first. Of the 32-bit word, `cmd` is bits 27..24, `addr` is bits 23..20 and `data` is bits 19..4. Bits 31..28 and 3..0 are ignored.
- R4: If select rises after fewer than 32 falling edges, including after exactly 31, no pulse occurs and the outputs keep their previous values.
- R5: A frame that follows an aborted frame is decoded from its own 32 bits only, with no leftover bits from the aborted frame.
- R6: After the 32nd falling edge, further falling edges while select stays low produce no pulse and do not alter the outputs.
- R7: A frame begins only when select falls after it has been seen high. If select is low when reset ends, clock edges are ignored until select has gone high and then low.
- R8: If the 32nd falling edge and the select rise reach the block in the same system cycle, the frame is accepted.
- R9: `cmd`, `addr` and `data` change only in a cycle where `frame_valid` is 1. They hold their values in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the serial clock rate |
| rst | input | 1 | Synchronous active-high reset |
| sel_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock; data is captured on its falling edge |
| sdi | input | 1 | Serial data input |
| frame_valid | output | 1 | One-cycle strobe marking a newly accepted frame |
| cmd | output | 4 | Command field of the last accepted frame |
| addr | output | 4 | Address field of the last accepted frame |
| data | output | 16 | Data field of the last accepted frame |

## Verification
Two functions can land in the same system cycle: the final falling edge that completes a frame, and the select rise that aborts one. The bench provokes this by moving `sclk` low and `sel_n` high at the same instant. Both signals pass through synchronisers of equal depth, so they are seen together. The expected result is one accepted frame with the correct fields. The bench also raises select right after the 31st edge, and in that case it expects no pulse and unchanged outputs.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

    localparam int unsigned PAD_LO_W  = 4;
    localparam int unsigned DATA_W    = 16;
    localparam int unsigned ADDR_W    = 4;
    localparam int unsigned CMD_W     = 4;
    localparam int unsigned PAD_HI_W  = 4;
    localparam int unsigned DATA_LSB  = PAD_LO_W;
    localparam int unsigned ADDR_LSB  = DATA_LSB + DATA_W;
    localparam int unsigned CMD_LSB   = ADDR_LSB + ADDR_W;
    localparam int unsigned FRAME_W   = CMD_LSB + CMD_W + PAD_HI_W;
    localparam int unsigned CNT_W     = $clog2(FRAME_W);

    typedef logic [FRAME_W-1:0] frame_word_t;

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } frame_fields_t;

    typedef enum logic [1:0] {
        ST_WAIT_HIGH = 2'd0,
        ST_ARMED     = 2'd1,
        ST_SHIFT     = 2'd2
    } rx_state_e;

    function automatic frame_fields_t split_word(input frame_word_t w);
        frame_fields_t f;
        f.cmd  = w[CMD_LSB  +: CMD_W];
        f.addr = w[ADDR_LSB +: ADDR_W];
        f.data = w[DATA_LSB +: DATA_W];
        return f;
    endfunction

endpackage

// File: rtl/sfr_sync.sv
module sfr_sync #(
    parameter int unsigned WIDTH  = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) begin
                chain <= '0;
            end else begin
                chain <= {chain[STAGES-2:0], async_i[b]};
            end
        end
        assign sync_o[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/sfr_edge.sv
module sfr_edge (
    input  logic clk,
    input  logic rst,
    input  logic sclk_s,
    output logic sclk_fall
);

    logic sclk_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_d <= 1'b0;
        end else begin
            sclk_d <= sclk_s;
        end
    end

    assign sclk_fall = sclk_d & ~sclk_s;

endmodule

// File: rtl/sfr_shifter.sv
module sfr_shifter
    import sfr_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        sel_hi,
    input  logic        sclk_fall,
    input  logic        sdi_s,
    output logic        done_o,
    output frame_word_t word_o
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_W - 1);

    rx_state_e        state;
    logic [CNT_W-1:0] cnt;
    frame_word_t      sr;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_WAIT_HIGH;
            cnt    <= '0;
            sr     <= '0;
            done_o <= 1'b0;
            word_o <= '0;
        end else begin
            done_o <= 1'b0;
            unique case (state)
                ST_WAIT_HIGH: begin
                    cnt <= '0;
                    if (sel_hi) state <= ST_ARMED;
                end
                ST_ARMED: begin
                    cnt <= '0;
                    if (!sel_hi) state <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (sclk_fall) begin
                        if (cnt == LAST_IDX) begin
                            done_o <= 1'b1;
                            word_o <= {sr[FRAME_W-2:0], sdi_s};
                            sr     <= '0;
                            cnt    <= '0;
                            state  <= ST_WAIT_HIGH;
                        end else begin
                            sr  <= {sr[FRAME_W-2:0], sdi_s};
                            cnt <= cnt + 1'b1;
                        end
                    end else if (sel_hi) begin
                        sr    <= '0;
                        cnt   <= '0;
                        state <= ST_ARMED;
                    end
                end
                default: state <= ST_WAIT_HIGH;
            endcase
        end
    end

    // R4
    abort_clears_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_SHIFT && sel_hi && !sclk_fall)
        |=> (cnt == '0 && sr == '0 && state == ST_ARMED && !done_o));

    // R6
    idle_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_WAIT_HIGH) |=> !done_o);

    // R2
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

endmodule

// File: rtl/sfr_decode.sv
module sfr_decode
    import sfr_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          done_i,
    input  frame_word_t   word_i,
    output logic          valid_o,
    output frame_fields_t fields_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_o  <= 1'b0;
            fields_o <= '0;
        end else begin
            valid_o <= done_i;
            if (done_i) fields_o <= split_word(word_i);
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!valid_o && fields_o == '0));

    // R2
    valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);

    // R9
    hold_fields_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(fields_o));

endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
    import sfr_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              frame_valid,
    output logic [CMD_W-1:0]  cmd,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);

    logic [2:0]    pins_s;
    logic          sclk_fall;
    logic          done;
    frame_word_t   word;
    frame_fields_t fields;

    sfr_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i ({sel_n, sclk, sdi}),
        .sync_o  (pins_s)
    );

    sfr_edge u_edge (
        .clk       (clk),
        .rst       (rst),
        .sclk_s    (pins_s[1]),
        .sclk_fall (sclk_fall)
    );

    sfr_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .sel_hi    (pins_s[2]),
        .sclk_fall (sclk_fall),
        .sdi_s     (pins_s[0]),
        .done_o    (done),
        .word_o    (word)
    );

    sfr_decode u_dec (
        .clk      (clk),
        .rst      (rst),
        .done_i   (done),
        .word_i   (word),
        .valid_o  (frame_valid),
        .fields_o (fields)
    );

    assign cmd  = fields.cmd;
    assign addr = fields.addr;
    assign data = fields.data;

endmodule

// File: tb/serial_frame_rx_tb_top.sv
`timescale 1ns/1ps
module serial_frame_rx_tb_top;

    localparam int HALF     = 4;
    localparam int NVEC     = 6;
    localparam int WD_LIMIT = 100000;

    localparam logic [55:0] VEC [NVEC] = '{
        {32'hF3A1_2345, 4'h3, 4'hA, 16'h1234},
        {32'h0000_0000, 4'h0, 4'h0, 16'h0000},
        {32'hFFFF_FFFF, 4'hF, 4'hF, 16'hFFFF},
        {32'h5C7B_EEF0, 4'hC, 4'h7, 16'hBEEF},
        {32'hA2E8_0010, 4'h2, 4'hE, 16'h8001},
        {32'h0915_5A5F, 4'h9, 4'h1, 16'h55A5}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n = 1'b1;
    logic        sclk = 1'b1;
    logic        sdi = 1'b0;
    logic        frame_valid;
    logic [3:0]  cmd;
    logic [3:0]  addr;
    logic [15:0] data;

    int total = 0;
    int bad = 0;
    int pulses = 0;
    int wide = 0;
    int cycles = 0;
    bit prev_v = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    serial_frame_rx dut_i (
        .clk(clk), .rst(rst), .sel_n(sel_n), .sclk(sclk), .sdi(sdi),
        .frame_valid(frame_valid), .cmd(cmd), .addr(addr), .data(data)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (frame_valid) pulses++;
            if (frame_valid && prev_v) wide++;
            prev_v = frame_valid;
        end else begin
            prev_v = 1'b0;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT && !finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=%0d", cycles, WD_LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive_frame(input logic [31:0] w, input int nbits,
                               input bit merge_last, input int extra);
        sel_n = 1'b0;
        wait_cyc(4);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b1;
            sdi  = w[31-i];
            wait_cyc(HALF);
            sclk = 1'b0;
            if (merge_last && i == nbits - 1) sel_n = 1'b1;
            wait_cyc(HALF);
        end
        for (int k = 0; k < extra; k++) begin
            sclk = 1'b1; sdi = ~sdi;
            wait_cyc(HALF);
            sclk = 1'b0;
            wait_cyc(HALF);
        end
        sclk  = 1'b1;
        sel_n = 1'b1;
        wait_cyc(12);
    endtask

    task automatic check_fields(input string req, input logic [3:0] c,
                                input logic [3:0] a, input logic [15:0] d);
        check(req, {cmd, addr, data}, {c, a, d});
    endtask

    initial begin
        int p0;
        wait_cyc(3);
        // R1: reset state
        check("R1 valid in reset", frame_valid, 0);
        check_fields("R1 fields in reset", 4'h0, 4'h0, 16'h0);
        rst = 1'b0;
        wait_cyc(1);
        check("R1 valid after reset", frame_valid, 0);
        wait_cyc(4);

        // R3 / R2: vector table
        for (int v = 0; v < NVEC; v++) begin
            p0 = pulses;
            drive_frame(VEC[v][55:24], 32, 1'b0, 0);
            check("R2 one pulse per frame", pulses - p0, 1);
            check_fields("R3 field mapping", VEC[v][23:20], VEC[v][19:16], VEC[v][15:0]);
        end

        // R4: abort after 20 bits
        p0 = pulses;
        drive_frame(32'hF7B6_ABCD, 20, 1'b0, 0);
        check("R4 abort at 20 no pulse", pulses - p0, 0);
        check_fields("R4 abort keeps outputs", 4'h9, 4'h1, 16'h55A5);

        // R5: clean frame after abort
        p0 = pulses;
        drive_frame(32'h0426_8AC0, 32, 1'b0, 0);
        check("R5 pulse after abort", pulses - p0, 1);
        check_fields("R5 fresh decode", 4'h4, 4'h2, 16'h68AC);

        // R4: abort after 31 bits
        p0 = pulses;
        drive_frame(32'hFFFF_FFFF, 31, 1'b0, 0);
        check("R4 abort at 31 no pulse", pulses - p0, 0);
        // R9: outputs held
        check_fields("R9 outputs held", 4'h4, 4'h2, 16'h68AC);

        // R6: extra edges after completion
        p0 = pulses;
        drive_frame(32'h1B3C_1357, 32, 1'b0, 9);
        check("R6 single pulse with extra edges", pulses - p0, 1);
        check_fields("R6 extra edges ignored", 4'hB, 4'h3, 16'hC135);

        // R8: 32nd fall and select rise together
        p0 = pulses;
        drive_frame(32'h2D94_2468, 32, 1'b1, 0);
        check("R8 merged edge accepted", pulses - p0, 1);
        check_fields("R8 merged fields", 4'hD, 4'h9, 16'h4246);

        // R7: select already low when reset ends
        sel_n = 1'b0;
        rst = 1'b1;
        wait_cyc(4);
        check_fields("R1 fields cleared by reset", 4'h0, 4'h0, 16'h0);
        rst = 1'b0;
        wait_cyc(4);
        p0 = pulses;
        drive_frame(32'h0F0F_0F0F, 32, 1'b0, 0);
        check("R7 no frame without select high", pulses - p0, 0);
        check_fields("R7 outputs untouched", 4'h0, 4'h0, 16'h0);
        p0 = pulses;
        drive_frame(32'h37E5_5550, 32, 1'b0, 0);
        check("R7 frame after select cycle", pulses - p0, 1);
        check_fields("R7 fields after select cycle", 4'h7, 4'hE, 16'h5555);

        // R2: every pulse one cycle wide
        check("R2 pulse width", wide, 0);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule